// File: doc/BRIEF.md
# I2C Controller Operating-Mode Register

This block is the CPU-visible register that sets how an I2C controller operates. It holds four control bits: a module enable, an interrupt enable, a master/slave select and a transmit/receive select. From the enable it derives the pin-function select, the hold on the controller's internal state and the select for the register bank behind a shared address. The enable also gates the controller's interrupt request lines.

The register does not simply keep what the CPU last wrote. It reacts to strobes from the bus engine. An arbitration loss in master mode clears both mode bits. When the controller is a slave, the direction bit is loaded from the R/W bit of the first frame after a start condition. A CPU change of direction made while a transfer is active is held in a shadow bit and applied only once the acknowledge frame has finished. The shift engine, start/stop generation and arbitration detection are outside this block.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset, all four control bits are 0, no deferred direction write is pending, and `cpu_rdata` reads 0.
- R2: On a clock edge with `cpu_wr` high, `cpu_wdata[7]`, `[6]` and `[5]` load enable, interrupt enable and master select. From the next cycle `cpu_rdata` returns enable, interrupt enable, master and transmit at bits 7, 6, 5 and 4, with every other bit 0.
- R3: While enable is 0, `pins_port` and `core_init` are 1 and `bank_mode` is 0, which selects the slave-address bank. While enable is 1, `pins_port` and `core_init` are 0 and `bank_mode` is 1, which selects the mode/data bank.
- R4: `irq_out` equals `irq_req` while interrupt enable is 1, and is all zeros while it is 0.
- R5: When `arb_lost` is high while master is 1 and `addr_fmt` is 1, the next cycle shows master and transmit both at 0. If master is 0 or `addr_fmt` is 0, `arb_lost` has no effect.
- R6: When the controller is enabled, in slave mode, with `addr_fmt` 1, the first `rw_cap` strobe after `start_det` loads transmit from `rw_bit` (1 means slave transmit, 0 means slave receive). Any later `rw_cap`, or one that comes after `frame1_done`, is ignored until the next `start_det`.
- R7: A CPU write while `xfer_active` is 0 loads transmit from `cpu_wdata[4]` at the next edge. A write while `xfer_active` is 1 leaves transmit unchanged and stores the bit as pending. The pending bit is applied at the edge where `ack_done` is high.
- R8: An arbitration loss that clears the mode bits also discards a pending direction write, including when `ack_done` arrives in the same cycle.
- R9: Whenever enable becomes 0, master and transmit go to 0 and any pending direction write is dropped, so a later `ack_done` leaves transmit at 0.
- R10: If a CPU write during a transfer comes in the same cycle as `ack_done`, the older pending value is applied at that edge. The new value stays pending until the next `ack_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | DATA_W | CPU write data (bits 7..4 used) |
| cpu_rdata | output | DATA_W | Register readback |
| start_det | input | 1 | Start condition seen on the bus |
| rw_cap | input | 1 | R/W bit of the current frame has been captured |
| rw_bit | input | 1 | Captured R/W value |
| frame1_done | input | 1 | First frame after start has completed |
| ack_done | input | 1 | Frame carrying the acknowledge bit has completed |
| xfer_active | input | 1 | A transfer is in progress |
| arb_lost | input | 1 | Arbitration lost strobe |
| addr_fmt | input | 1 | Addressing format selected |
| irq_req | input | IRQ_N | Raw interrupt requests from the controller |
| mode_en | output | 1 | Module enable bit |
| irq_en | output | 1 | Interrupt enable bit |
| master | output | 1 | 1 = master, 0 = slave |
| transmit | output | 1 | 1 = transmit, 0 = receive |
| pins_port | output | 1 | 1 = SCL/SDA returned to general port function |
| core_init | output | 1 | 1 = controller internal state held in initialization |
| bank_mode | output | 1 | 1 = mode/data bank, 0 = slave-address bank |
| irq_out | output | IRQ_N | Masked interrupt requests |

## Verification
The bench builds the block with a 16-bit data path and three interrupt lines. With these values it checks that the bits above 7 read back as zero and that each interrupt line is masked on its own. It keeps the deferred-direction variant, since that is the only one in which R7, R8 and R10 can be observed. A behavioural model is stepped alongside the design on every clock. The stimulus is chosen to make arbitration loss, acknowledge completion and CPU writes coincide.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
   // Field positions decoded by software; fixed by the register layout.
   localparam int EN_POS = 7;
   localparam int IE_POS = 6;
   localparam int MS_POS = 5;
   localparam int TR_POS = 4;
   localparam int CTRL_BITS = 8;

   typedef struct packed {
      logic en;
      logic ie;
      logic ms;
      logic tr;
   } mode_bits_t;
endpackage

// File: rtl/mcr_start_tracker.sv
// Remembers that a start was seen and the first frame's R/W bit is still due.
module mcr_start_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic keep,
   input  logic start_det,
   input  logic rw_cap,
   input  logic frame1_done,
   output logic armed
);
   logic armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (!keep) begin
         armed_q <= 1'b0;
      end else if (start_det) begin
         armed_q <= 1'b1;
      end else if (rw_cap || frame1_done) begin
         armed_q <= 1'b0;
      end
   end

   assign armed = armed_q;
endmodule

// File: rtl/mcr_dir_ctrl.sv
// Direction (transmit/receive) bit with optional deferral of CPU writes.
module mcr_dir_ctrl #(
   parameter bit DEFER_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_tr,
   input  logic xfer_active,
   input  logic ack_done,
   input  logic rw_load,
   input  logic rw_bit,
   input  logic hw_clear,
   output logic tr,
   output logic pend_vld
);
   logic tr_q, tr_d;

   generate
      if (DEFER_EN) begin : g_defer
         logic pv_q, pv_d;
         logic pd_q, pd_d;

         always_comb begin
            tr_d = tr_q;
            pv_d = pv_q;
            pd_d = pd_q;
            // retire the older pending value first
            if (ack_done && pv_q) begin
               tr_d = pd_q;
               pv_d = 1'b0;
            end
            if (wr) begin
               if (xfer_active) begin
                  pv_d = 1'b1;
                  pd_d = wr_tr;
               end else begin
                  tr_d = wr_tr;
                  pv_d = 1'b0;
               end
            end
            if (rw_load) begin
               tr_d = rw_bit;
            end
            if (hw_clear) begin
               tr_d = 1'b0;
               pv_d = 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pv_q <= 1'b0;
               pd_q <= 1'b0;
            end else begin
               pv_q <= pv_d;
               pd_q <= pd_d;
            end
         end

         assign pend_vld = pv_q;
      end else begin : g_direct
         logic unused_defer;
         assign unused_defer = xfer_active ^ ack_done;

         always_comb begin
            tr_d = tr_q;
            if (wr)       tr_d = wr_tr;
            if (rw_load)  tr_d = rw_bit;
            if (hw_clear) tr_d = 1'b0;
         end

         assign pend_vld = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) tr_q <= 1'b0;
      else        tr_q <= tr_d;
   end

   assign tr = tr_q;
endmodule

// File: rtl/mcr_out_decode.sv
// Derived pin, bank and interrupt controls.
module mcr_out_decode #(
   parameter int IRQ_N = 1
) (
   input  logic             en,
   input  logic             ie,
   input  logic [IRQ_N-1:0] irq_req,
   output logic             pins_port,
   output logic             core_init,
   output logic             bank_mode,
   output logic [IRQ_N-1:0] irq_out
);
   assign pins_port = ~en;
   assign core_init = ~en;
   assign bank_mode = en;

   generate
      for (genvar i = 0; i < IRQ_N; i++) begin : g_mask
         assign irq_out[i] = irq_req[i] & ie;
      end
   endgenerate
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl #(
   parameter int DATA_W   = 8,
   parameter int IRQ_N    = 1,
   parameter bit DEFER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              start_det,
   input  logic              rw_cap,
   input  logic              rw_bit,
   input  logic              frame1_done,
   input  logic              ack_done,
   input  logic              xfer_active,
   input  logic              arb_lost,
   input  logic              addr_fmt,
   input  logic [IRQ_N-1:0]  irq_req,
   output logic              mode_en,
   output logic              irq_en,
   output logic              master,
   output logic              transmit,
   output logic              pins_port,
   output logic              core_init,
   output logic              bank_mode,
   output logic [IRQ_N-1:0]  irq_out
);
   import i2c_mode_pkg::*;

   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << EN_POS) | (1 << IE_POS) | (1 << MS_POS) | (1 << TR_POS));

   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_w
         $error("i2c_mode_ctrl: DATA_W must be at least 8");
      end
      if (IRQ_N < 1) begin : g_bad_irq
         $error("i2c_mode_ctrl: IRQ_N must be at least 1");
      end
   endgenerate

   mode_bits_t q;
   logic en_d, ie_d, ms_d;
   logic arb_clr, rw_load, armed, pend_vld, tr;

   assign arb_clr = arb_lost & q.ms & addr_fmt;
   assign rw_load = armed & rw_cap & ~q.ms & addr_fmt & q.en;

   always_comb begin
      en_d = q.en;
      ie_d = q.ie;
      ms_d = q.ms;
      if (cpu_wr) begin
         en_d = cpu_wdata[EN_POS];
         ie_d = cpu_wdata[IE_POS];
         ms_d = cpu_wdata[MS_POS];
      end
      if (arb_clr) ms_d = 1'b0;
      if (!en_d)   ms_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q.en <= 1'b0;
         q.ie <= 1'b0;
         q.ms <= 1'b0;
      end else begin
         q.en <= en_d;
         q.ie <= ie_d;
         q.ms <= ms_d;
      end
   end

   mcr_start_tracker u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .keep        (en_d),
      .start_det   (start_det),
      .rw_cap      (rw_cap),
      .frame1_done (frame1_done),
      .armed       (armed)
   );

   mcr_dir_ctrl #(.DEFER_EN(DEFER_EN)) u_dir (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (cpu_wr),
      .wr_tr       (cpu_wdata[TR_POS]),
      .xfer_active (xfer_active),
      .ack_done    (ack_done),
      .rw_load     (rw_load),
      .rw_bit      (rw_bit),
      .hw_clear    (arb_clr | ~en_d),
      .tr          (tr),
      .pend_vld    (pend_vld)
   );

   assign q.tr = tr;

   mcr_out_decode #(.IRQ_N(IRQ_N)) u_dec (
      .en        (q.en),
      .ie        (q.ie),
      .irq_req   (irq_req),
      .pins_port (pins_port),
      .core_init (core_init),
      .bank_mode (bank_mode),
      .irq_out   (irq_out)
   );

   always_comb begin
      cpu_rdata         = '0;
      cpu_rdata[EN_POS] = q.en;
      cpu_rdata[IE_POS] = q.ie;
      cpu_rdata[MS_POS] = q.ms;
      cpu_rdata[TR_POS] = q.tr;
   end

   logic unused_wbits;
   assign unused_wbits = ^{cpu_wdata & ~CTRL_MASK, pend_vld};

   assign mode_en  = q.en;
   assign irq_en   = q.ie;
   assign master   = q.ms;
   assign transmit = q.tr;
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk #(
   parameter int DATA_W   = 8,
   parameter int IRQ_N    = 1,
   parameter bit DEFER_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_wr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic              rw_cap,
   input logic              ack_done,
   input logic              xfer_active,
   input logic              arb_lost,
   input logic              addr_fmt,
   input logic [IRQ_N-1:0]  irq_out,
   input logic              mode_en,
   input logic              irq_en,
   input logic              master,
   input logic              transmit,
   input logic              pins_port,
   input logic              core_init,
   input logic              bank_mode
);
   // R2
   ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |=> irq_en == $past(cpu_wdata[6]));

   // R3
   enabled_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_en |-> (!pins_port && !core_init && bank_mode));

   // R4
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> (irq_out == '0));

   // R5
   arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && master && addr_fmt) |=> (!master && !transmit));

   // R9
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |-> (!master && !transmit));

   generate
      if (DEFER_EN) begin : g_defer_chk
         // R7
         defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr && cpu_wdata[7] && xfer_active && !ack_done && !rw_cap && !arb_lost)
               |=> $stable(transmit));
      end
   endgenerate
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk #(
   .DATA_W(DATA_W), .IRQ_N(IRQ_N), .DEFER_EN(DEFER_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
   .rw_cap(rw_cap), .ack_done(ack_done), .xfer_active(xfer_active),
   .arb_lost(arb_lost), .addr_fmt(addr_fmt), .irq_out(irq_out),
   .mode_en(mode_en), .irq_en(irq_en), .master(master), .transmit(transmit),
   .pins_port(pins_port), .core_init(core_init), .bank_mode(bank_mode)
);

// File: tb/test_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module test_i2c_mode_ctrl;
   localparam int DW = 16;
   localparam int NI = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic start_det = 0, rw_cap = 0, rw_bit = 0, frame1_done = 0, ack_done = 0;
   logic xfer_active = 0, arb_lost = 0, addr_fmt = 0;
   logic [NI-1:0] irq_req = '0;
   logic [NI-1:0] irq_out;
   logic mode_en, irq_en, master, transmit, pins_port, core_init, bank_mode;

   i2c_mode_ctrl #(.DATA_W(DW), .IRQ_N(NI), .DEFER_EN(1'b1)) i_i2c_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .start_det(start_det), .rw_cap(rw_cap),
      .rw_bit(rw_bit), .frame1_done(frame1_done), .ack_done(ack_done),
      .xfer_active(xfer_active), .arb_lost(arb_lost), .addr_fmt(addr_fmt),
      .irq_req(irq_req), .mode_en(mode_en), .irq_en(irq_en), .master(master),
      .transmit(transmit), .pins_port(pins_port), .core_init(core_init),
      .bank_mode(bank_mode), .irq_out(irq_out)
   );

   int total = 0;
   int bad = 0;
   string tag = "R1";

   // reference model state
   bit m_en, m_ie, m_ms, m_tr, m_pv, m_pd, m_arm;

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      bit n_en, n_ie, n_ms, n_tr, n_pv, n_pd, n_arm;
      if (!rst_n) begin
         {m_en, m_ie, m_ms, m_tr, m_pv, m_pd, m_arm} = '0;
         return;
      end
      n_en = m_en; n_ie = m_ie; n_ms = m_ms; n_tr = m_tr;
      n_pv = m_pv; n_pd = m_pd; n_arm = m_arm;
      if (ack_done && m_pv) begin n_tr = m_pd; n_pv = 0; end
      if (cpu_wr) begin
         n_en = cpu_wdata[7]; n_ie = cpu_wdata[6]; n_ms = cpu_wdata[5];
         if (xfer_active) begin n_pv = 1; n_pd = cpu_wdata[4]; end
         else begin n_tr = cpu_wdata[4]; n_pv = 0; end
      end
      if (m_arm && rw_cap && !m_ms && addr_fmt && m_en) n_tr = rw_bit;
      if (start_det) n_arm = 1;
      else if (rw_cap || frame1_done) n_arm = 0;
      if (arb_lost && m_ms && addr_fmt) begin n_ms = 0; n_tr = 0; n_pv = 0; end
      if (!n_en) begin n_ms = 0; n_tr = 0; n_pv = 0; n_arm = 0; end
      m_en = n_en; m_ie = n_ie; m_ms = n_ms; m_tr = n_tr;
      m_pv = n_pv; m_pd = n_pd; m_arm = n_arm;
   endtask

   task automatic compare();
      logic [DW-1:0] rd;
      rd = '0;
      rd[7] = m_en; rd[6] = m_ie; rd[5] = m_ms; rd[4] = m_tr;
      chk("cpu_rdata", int'(cpu_rdata), int'(rd));
      chk("master", int'(master), int'(m_ms));
      chk("transmit", int'(transmit), int'(m_tr));
      chk("mode_en", int'(mode_en), int'(m_en));
      chk("irq_en", int'(irq_en), int'(m_ie));
      chk("pins_port", int'(pins_port), int'(!m_en));
      chk("core_init", int'(core_init), int'(!m_en));
      chk("bank_mode", int'(bank_mode), int'(m_en));
      chk("irq_out", int'(irq_out), int'(irq_req & {NI{m_ie}}));
   endtask

   // one clock: the design and the model see the same inputs at the edge
   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      cpu_wr = 0; start_det = 0; rw_cap = 0; frame1_done = 0;
      ack_done = 0; arb_lost = 0;
   endtask

   task automatic wr(logic [7:0] v);
      cpu_wr = 1; cpu_wdata = {{(DW-8){1'b1}}, v};
      step();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      #(4 * 20000);
      bad++; total++;
      $display("FAIL watchdog expired in %s", tag);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R1 reset state
      tag = "R1"; idle(3);
      rst_n = 1; idle(2);

      // R3 disabled outputs, then enabled
      tag = "R3"; irq_req = 3'b101; idle(1);
      wr(8'h80); idle(1);

      // R4 interrupt pass and mask
      tag = "R4"; wr(8'hC0); irq_req = 3'b011; idle(1);
      irq_req = 3'b110; idle(1); wr(8'h80); idle(1);

      // R2 field loads and readback, upper bits written as ones
      tag = "R2"; wr(8'hFF); wr(8'hA5); wr(8'hE0); idle(1);

      // R5 arbitration loss cases
      tag = "R5"; addr_fmt = 1; wr(8'hB0); arb_lost = 1; step(); idle(1);
      addr_fmt = 0; wr(8'hB0); arb_lost = 1; step(); idle(1);
      addr_fmt = 1; wr(8'h90); arb_lost = 1; step(); idle(1);

      // R6 R/W load from first frame only
      tag = "R6"; wr(8'h80); start_det = 1; step(); idle(1);
      rw_bit = 1; rw_cap = 1; step(); idle(1);
      rw_bit = 0; rw_cap = 1; step(); idle(1);
      start_det = 1; step(); rw_bit = 0; rw_cap = 1; step(); idle(1);
      start_det = 1; step(); frame1_done = 1; step();
      rw_bit = 1; rw_cap = 1; step(); idle(1);
      addr_fmt = 0; start_det = 1; step(); rw_bit = 1; rw_cap = 1; step();
      addr_fmt = 1; idle(1);

      // R7 deferred and immediate direction writes
      tag = "R7"; wr(8'hA0); xfer_active = 1; wr(8'hB0); idle(3);
      ack_done = 1; step(); idle(1);
      xfer_active = 0; wr(8'hA0); idle(1);

      // R8 arbitration loss with ack completion in the same cycle
      tag = "R8"; xfer_active = 1; wr(8'hB0); idle(1);
      ack_done = 1; arb_lost = 1; step(); idle(1);
      ack_done = 1; step(); idle(1);

      // R10 write coinciding with ack completion
      tag = "R10"; wr(8'hB0); ack_done = 1; cpu_wr = 1;
      cpu_wdata = {{(DW-8){1'b0}}, 8'hA0}; step(); idle(1);
      ack_done = 1; step(); idle(1);

      // R9 disable drops pending and mode bits
      tag = "R9"; xfer_active = 1; wr(8'hB0); wr(8'h30); idle(1);
      ack_done = 1; step(); idle(1);
      xfer_active = 0; wr(8'hB0); wr(8'h00); idle(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule